// File: doc/BRIEF.md
# Synchronised Multi-Channel Timer Group

This block holds a set of 16-bit up-counters, one per channel, that share a small control space. Each channel counts on its own enable input. Software writes a counter through a single write port.

A synchronisation mask marks channels as members of a group. A write to any member's counter loads the same value into every member on the same clock edge. A clear request raised by any member zeroes every member in that same cycle.

Two fixed pairs of adjacent channels can be chained into 32-bit counters. The pairs are channel 1 with channel 2, and channel 4 with channel 5. In a chained pair the upper channel advances once each time the lower channel wraps. The pair outputs present both halves as registered on the same edge.

Top module: `tmr_sync_group`

## Requirements
- R1: While reset is high and after its release, every counter reads zero, the synchronisation mask is empty and both pairs are unchained.
- R2: A channel whose enable is high advances by one per clock and wraps from 0xFFFF to 0x0000, unless it is loaded, cleared or chained as an upper half.
- R3: A write to address i (0 to NCH-1) loads channel i on the next edge. A write to address NCH sets the synchronisation mask, with bit i of the data for channel i. A write to address NCH+1 sets the chain selects: data bit 0 chains channels 1/2 and data bit 1 chains channels 4/5.
- R4: A write to the counter of a channel in the mask loads the written value into every channel in the mask on the same edge.
- R5: A clear request on a channel zeroes that channel. If that channel is in the mask, the request also zeroes every channel in the mask on the same edge.
- R6: A channel outside the mask is unaffected by writes to, or clear requests of, other channels.
- R7: When a load and a clear reach a channel in the same cycle, the load wins.
- R8: In a chained pair, the upper channel ignores its own enable. It advances by exactly one on the edge where the lower channel counts from 0xFFFF to 0x0000, and holds otherwise, unless it is itself loaded or cleared.
- R9: Pair output p equals {upper counter, lower counter}, both halves taken from the same edge. Pair 0 is channels 2:1 and pair 1 is channels 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW (3) | Write address: counters, then mask, then chain selects |
| wr_data | input | CW (16) | Write data |
| cnt_en | input | NCH (6) | Per-channel count enable |
| clr_req | input | NCH (6) | Per-channel clear request |
| cnt_val | output | NCH*CW (96) | Counter values, channel i at bits [i*CW +: CW] |
| pair_val | output | 2*2*CW (64) | Chained 32-bit values, pair p at bits [p*2*CW +: 2*CW] |

## Verification
The hardest case to reach from the ports is a lower-half wrap that meets a load or clear on the same edge. The load or clear can hit the lower channel, which must suppress the carry, or the upper channel, which must take precedence over the carry. Directed phases preload the lower counters a few counts below 0xFFFF and toggle the upper enable to show it is ignored. A long random phase then biases write data toward the top of the range. It mixes writes, mask changes and sparse clear requests, so that wraps, group loads and group clears overlap.

// File: rtl/tmr_grp_pkg.sv
package tmr_grp_pkg;

    localparam int unsigned NPAIR = 2;

    typedef struct packed {
        logic load;
        logic clear;
    } chan_ctl_t;

    function automatic int pair_lower(input int p);
        return (p == 0) ? 1 : 4;
    endfunction

    function automatic bit is_upper(input int i);
        return (i == 2) || (i == 5);
    endfunction

    function automatic int pair_of_upper(input int i);
        return (i == 2) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tmr_grp_ctl.sv
module tmr_grp_ctl
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NCH = 6,
    parameter int unsigned CW  = 16,
    parameter int unsigned AW  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [CW-1:0]              wr_data,
    input  logic [NCH-1:0]             clr_req,
    output chan_ctl_t [NCH-1:0]        ctl_o,
    output logic [NCH-1:0]             sync_o,
    output logic [NPAIR-1:0]           cas_o
);
    localparam int unsigned MASK_ADDR = NCH;
    localparam int unsigned CAS_ADDR  = NCH + 1;

    logic [NCH-1:0]   sync_q;
    logic [NPAIR-1:0] cas_q;
    logic [NCH-1:0]   direct_hit;
    logic             group_load;
    logic             group_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cas_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(MASK_ADDR)) sync_q <= wr_data[NCH-1:0];
            if (wr_addr == AW'(CAS_ADDR))  cas_q  <= wr_data[NPAIR-1:0];
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            direct_hit[i] = wr_en && (wr_addr == AW'(i));
        end
        group_load  = |(direct_hit & sync_q);
        group_clear = |(clr_req & sync_q);
        for (int i = 0; i < NCH; i++) begin
            ctl_o[i].load  = direct_hit[i] | (group_load & sync_q[i]);
            ctl_o[i].clear = clr_req[i] | (group_clear & sync_q[i]);
        end
    end

    assign sync_o = sync_q;
    assign cas_o  = cas_q;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] data,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load)  cnt_q <= data;
        else if (clear) cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + CW'(1);
    end

    assign wrap_o = tick && !load && !clear && (cnt_q == '1);
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/tmr_sync_group.sv
module tmr_sync_group
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NCH = 6,
    parameter int unsigned CW  = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [$clog2(NCH+2)-1:0]    wr_addr,
    input  logic [CW-1:0]               wr_data,
    input  logic [NCH-1:0]              cnt_en,
    input  logic [NCH-1:0]              clr_req,
    output logic [NCH*CW-1:0]           cnt_val,
    output logic [NPAIR*2*CW-1:0]       pair_val
);
    localparam int unsigned AW = $clog2(NCH + 2);

    chan_ctl_t [NCH-1:0]     ctl;
    logic [NCH-1:0]          sync_q;
    logic [NPAIR-1:0]        cas_q;
    logic [NCH-1:0][CW-1:0]  cnt_q;
    logic [NCH-1:0]          wrap;
    logic [NCH-1:0]          tick;

    tmr_grp_ctl #(.NCH(NCH), .CW(CW), .AW(AW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clr_req (clr_req),
        .ctl_o   (ctl),
        .sync_o  (sync_q),
        .cas_o   (cas_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (is_upper(i)) begin : g_up
            assign tick[i] = cas_q[pair_of_upper(i)] ? wrap[i-1] : cnt_en[i];
        end else begin : g_plain
            assign tick[i] = cnt_en[i];
        end

        tmr_chan #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .load   (ctl[i].load),
            .clear  (ctl[i].clear),
            .tick   (tick[i]),
            .data   (wr_data),
            .cnt_o  (cnt_q[i]),
            .wrap_o (wrap[i])
        );

        assign cnt_val[i*CW +: CW] = cnt_q[i];
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = pair_lower(p);
        assign pair_val[p*2*CW +: 2*CW] = {cnt_q[LO+1], cnt_q[LO]};
    end

endmodule

// File: rtl/tmr_grp_chk.sv
module tmr_grp_chk
    import tmr_grp_pkg::*;
#(
    parameter int unsigned NCH = 6,
    parameter int unsigned CW  = 16,
    parameter int unsigned AW  = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [AW-1:0]              wr_addr,
    input logic [CW-1:0]              wr_data,
    input logic [NCH-1:0]             cnt_en,
    input logic [NCH-1:0]             clr_req,
    input logic [NCH-1:0][CW-1:0]     cnt_q,
    input logic [NCH-1:0]             sync_q,
    input logic [NPAIR-1:0]           cas_q
);
    logic [NCH-1:0] hit;
    logic           wr_sync;
    logic           clr_sync;
    logic [NCH-1:0] ld_c;
    logic [NCH-1:0] cl_c;

    always_comb begin
        for (int i = 0; i < NCH; i++) hit[i] = wr_en && (wr_addr == AW'(i));
        wr_sync  = |(hit & sync_q);
        clr_sync = |(clr_req & sync_q);
        for (int i = 0; i < NCH; i++) begin
            ld_c[i] = hit[i] || (wr_sync && sync_q[i]);
            cl_c[i] = clr_req[i] || (clr_sync && sync_q[i]);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_a
        localparam bit UP = is_upper(i);
        localparam int PI = UP ? pair_of_upper(i) : 0;

        p_group_load_r4: assert property (@(posedge clk) disable iff (rst)
            wr_sync && sync_q[i] |=> cnt_q[i] == $past(wr_data));

        p_group_clear_r5: assert property (@(posedge clk) disable iff (rst)
            !ld_c[i] && sync_q[i] && clr_sync |=> cnt_q[i] == '0);

        p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
            hit[i] && clr_req[i] |=> cnt_q[i] == $past(wr_data));

        p_isolated_r6: assert property (@(posedge clk) disable iff (rst)
            !sync_q[i] && !hit[i] && !clr_req[i] && !cnt_en[i] && (!UP || !cas_q[PI])
            |=> $stable(cnt_q[i]));
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_p
        localparam int LO = pair_lower(p);
        localparam int HI = LO + 1;

        p_carry_step_r8: assert property (@(posedge clk) disable iff (rst)
            cas_q[p] && cnt_en[LO] && cnt_q[LO] == '1 && !ld_c[LO] && !cl_c[LO]
            && !ld_c[HI] && !cl_c[HI]
            |=> cnt_q[HI] == $past(cnt_q[HI]) + CW'(1));

        p_carry_hold_r8: assert property (@(posedge clk) disable iff (rst)
            cas_q[p] && cnt_q[LO] != '1 && !ld_c[HI] && !cl_c[HI]
            |=> $stable(cnt_q[HI]));
    end

endmodule

bind tmr_sync_group tmr_grp_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt_en  (cnt_en),
    .clr_req (clr_req),
    .cnt_q   (cnt_q),
    .sync_q  (sync_q),
    .cas_q   (cas_q)
);

// File: tb/sim_tmr_sync_group.sv
module sim_tmr_sync_group;
    localparam int NCH = 6;
    localparam int CW  = 16;
    localparam int AW  = 3;

    logic              clk = 0;
    logic              rst = 1;
    logic              wr_en = 0;
    logic [AW-1:0]     wr_addr = '0;
    logic [CW-1:0]     wr_data = '0;
    logic [NCH-1:0]    cnt_en = '0;
    logic [NCH-1:0]    clr_req = '0;
    logic [NCH*CW-1:0] cnt_val;
    logic [4*CW-1:0]   pair_val;

    int checks = 0;
    int fails  = 0;

    logic [CW-1:0] m_cnt [NCH];
    logic [NCH-1:0] m_sync;
    logic [1:0]     m_cas;

    always #10 clk = ~clk;

    tmr_sync_group u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_en(cnt_en), .clr_req(clr_req), .cnt_val(cnt_val), .pair_val(pair_val)
    );

    task automatic check(input string tag, input logic [2*CW-1:0] act, input logic [2*CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: one clock of the rules R1..R9
    task automatic model_update();
        logic [CW-1:0] nxt [NCH];
        bit sw, sc;
        bit ld [NCH];
        bit cl [NCH];
        bit lo_wrap [2];
        if (rst) begin
            foreach (m_cnt[i]) m_cnt[i] = '0;
            m_sync = '0; m_cas = '0;
            return;
        end
        sw = wr_en && wr_addr < NCH && m_sync[wr_addr];
        sc = (clr_req & m_sync) != 0;
        for (int i = 0; i < NCH; i++) begin
            ld[i] = wr_en && (wr_addr == i || (sw && m_sync[i]));
            cl[i] = clr_req[i] || (sc && m_sync[i]);
        end
        lo_wrap[0] = cnt_en[1] && !ld[1] && !cl[1] && m_cnt[1] == 16'hFFFF;
        lo_wrap[1] = cnt_en[4] && !ld[4] && !cl[4] && m_cnt[4] == 16'hFFFF;
        for (int i = 0; i < NCH; i++) begin
            bit adv;
            if (i == 2 && m_cas[0])      adv = lo_wrap[0];
            else if (i == 5 && m_cas[1]) adv = lo_wrap[1];
            else                         adv = cnt_en[i];
            if (ld[i])       nxt[i] = wr_data;
            else if (cl[i])  nxt[i] = '0;
            else if (adv)    nxt[i] = m_cnt[i] + 1'b1;
            else             nxt[i] = m_cnt[i];
        end
        if (wr_en && wr_addr == 6) m_sync = wr_data[NCH-1:0];
        if (wr_en && wr_addr == 7) m_cas  = wr_data[1:0];
        foreach (m_cnt[i]) m_cnt[i] = nxt[i];
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < NCH; i++)
            check(tag, {16'h0, cnt_val[i*CW +: CW]}, {16'h0, m_cnt[i]});
        check({tag, " R9 pair0"}, pair_val[0 +: 32], {m_cnt[2], m_cnt[1]});
        check({tag, " R9 pair1"}, pair_val[32 +: 32], {m_cnt[5], m_cnt[4]});
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        wr_en = 0; clr_req = '0;
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d, input string tag);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
        step(tag);
        wr_en = 0;
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        foreach (m_cnt[i]) m_cnt[i] = 'x;
        @(negedge clk);
        repeat (3) step("R1 in reset");
        rst = 0;
        step("R1 after release");

        cnt_en = '1;
        repeat (20) step("R2 free count");
        wr(3, 16'hFFFE, "R3 load ch3");
        repeat (3) step("R2 wrap");

        cnt_en = '0;
        wr(6, 16'h000D, "R3 mask write");
        wr(0, 16'h1234, "R4 group load");
        cnt_en = 6'b010010;
        wr(3, 16'h00AA, "R4 group load via ch3 R6");
        wr(1, 16'h0777, "R6 non-member write");
        clr_req = 6'b010000; step("R6 non-member clear R5"); idle();
        step("R6 settle");
        clr_req = 6'b000100; step("R5 group clear"); idle();
        wr_en = 1; wr_addr = 3; wr_data = 16'h5555; clr_req = 6'b000001;
        step("R7 group load beats group clear"); idle();
        wr_en = 1; wr_addr = 1; wr_data = 16'h4321; clr_req = 6'b000010;
        step("R7 own load beats own clear"); idle();

        cnt_en = '0;
        wr(6, 16'h0000, "R3 mask off");
        wr(7, 16'h0003, "R3 chain on");
        wr(1, 16'hFFFD, "R8 preload lower");
        wr(2, 16'h0010, "R8 preload upper");
        wr(4, 16'hFFFF, "R8 preload lower2");
        cnt_en = 6'b010010;
        repeat (6) step("R8 carry");
        cnt_en = 6'b100100;
        repeat (3) step("R8 upper ignores enable");
        wr(1, 16'hFFFF, "R8 reload lower");
        cnt_en = 6'b000010; clr_req = 6'b000100;
        step("R8 clear upper over carry"); idle();
        repeat (2) step("R8 after");

        for (int n = 0; n < 3000; n++) begin
            wr_en   = ($urandom_range(0, 7) == 0);
            wr_addr = AW'($urandom_range(0, 7));
            wr_data = $urandom_range(0, 1) ? {12'hFFF, 4'($urandom)} : 16'($urandom);
            cnt_en  = NCH'($urandom);
            clr_req = '0;
            for (int b = 0; b < NCH; b++) clr_req[b] = ($urandom_range(0, 15) == 0);
            step("random R2 R4 R5 R6 R7 R8");
        end
        idle();
        step("final");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule